// File: doc/BRIEF.md
# Sealed Domain Call Checker

This block decides whether a protected cross-domain call may go ahead. The call names two sealed capabilities. One is a code capability, which becomes the branch target. The other is a data capability, which becomes the invoked-data register. Each operand arrives as separate fields: a tag, a sealed flag, a 24-bit object type, an execute permission, a call permission, a base, a top and an offset. The block forms each cursor as base plus offset.

The block runs an ordered chain of checks over the two operands, and the first failing check sets the cause. The checks cover tags, seals, matching object types, opposite execute-permission rules and a one-byte bounds test on the code cursor. After those, a selector picks one of two forms. The trapping form always hands the call to software. The non-trapping form also requires the call permission on both operands. When every check passes, the block returns both capabilities with their seals removed, and the code cursor as the branch address.

A request is one cycle with `req_valid_i` high. The response appears, registered, on the next cycle with `rsp_valid_o` high.

Top module: `sealed_call_check`

## Requirements
- R1: If the code tag is clear, the block faults with cause 1 (tag) against operand 0 (code). Otherwise, if the data tag is clear, it faults with cause 1 against operand 1 (data).
- R2: If the code sealed flag is clear, the block faults with cause 2 (seal) against operand 0. Otherwise, if the data sealed flag is clear, it faults with cause 2 against operand 1.
- R3: If the two object types differ, or the code object type is greater than parameter MAX_SEALED_OT, the block faults with cause 3 (type) against operand 0.
- R4: If the code capability lacks execute permission, the block faults with cause 4 (execute permission) against operand 0.
- R5: If the data capability holds execute permission, the block faults with cause 4 against operand 1.
- R6: The code cursor, computed as base + offset modulo 2^AW, must pass a one-byte bounds test. It must be at least the base, cursor+1 must not carry out of AW bits, and cursor+1 must not exceed the top. Otherwise the block faults with cause 5 (length) against operand 0.
- R7: If all earlier checks pass and the selector is 0, the block faults with cause 6 (call trap) against operand 0.
- R8: If the selector is 1, each capability must hold the call permission. Otherwise the block faults with cause 7 (call permission), naming operand 0 first and operand 1 second.
- R9: The checks apply in the order R1, R2, R3, R4, R5, R6, then R7 or R8. The first failing check sets the cause and the operand.
- R10: On success, fault is 0 and cause is 0, and the target equals the code cursor. Both output capabilities have the tag set, the sealed flag clear and the object type 24'hFFFFFF. Their other fields are copied from the inputs.
- R11: On a fault, the target is 0 and every field of both output capabilities is 0. The cause is non-zero exactly when fault is set.
- R12: The response is valid exactly one cycle after a request, and `rsp_valid_o` is low otherwise. During reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe |
| sel_i | input | 1 | 0 = trapping form, 1 = non-trapping form |
| c_tag_i | input | 1 | Code capability tag |
| c_sealed_i | input | 1 | Code capability sealed flag |
| c_otype_i | input | 24 | Code object type |
| c_px_i | input | 1 | Code execute permission |
| c_pcall_i | input | 1 | Code call permission |
| c_base_i | input | AW | Code base |
| c_top_i | input | AW+1 | Code top |
| c_off_i | input | AW | Code offset |
| d_tag_i | input | 1 | Data capability tag |
| d_sealed_i | input | 1 | Data capability sealed flag |
| d_otype_i | input | 24 | Data object type |
| d_px_i | input | 1 | Data execute permission |
| d_pcall_i | input | 1 | Data call permission |
| d_base_i | input | AW | Data base |
| d_top_i | input | AW+1 | Data top |
| d_off_i | input | AW | Data offset |
| rsp_valid_o | output | 1 | Response valid |
| fault_o | output | 1 | Check failed |
| cause_o | output | 3 | Cause code (0 on success) |
| fault_opnd_o | output | 1 | Faulting operand: 0 code, 1 data |
| target_o | output | AW | Branch address |
| ud_tag_o | output | 1 | Unsealed data tag |
| ud_sealed_o | output | 1 | Unsealed data sealed flag |
| ud_otype_o | output | 24 | Unsealed data object type |
| ud_px_o | output | 1 | Unsealed data execute permission |
| ud_pcall_o | output | 1 | Unsealed data call permission |
| ud_base_o | output | AW | Unsealed data base |
| ud_top_o | output | AW+1 | Unsealed data top |
| ud_off_o | output | AW | Unsealed data offset |
| uc_tag_o | output | 1 | Unsealed code tag |
| uc_sealed_o | output | 1 | Unsealed code sealed flag |
| uc_otype_o | output | 24 | Unsealed code object type |
| uc_px_o | output | 1 | Unsealed code execute permission |
| uc_pcall_o | output | 1 | Unsealed code call permission |
| uc_base_o | output | AW | Unsealed code base |
| uc_top_o | output | AW+1 | Unsealed code top |
| uc_off_o | output | AW | Unsealed code offset |

## Verification
The assertions assume that the request inputs and the selector are steady through the cycle in which `req_valid_i` is sampled. The branch-address and trap properties compare the response against the inputs of that one previous cycle. The stimulus changes the inputs only on the falling edge and sends each request as a single-cycle strobe, separated by idle cycles. The operands start from one capability pair that passes every check. Each vector then breaks one field or a chosen combination of fields, which keeps the bounds values inside the carry and top ranges that R6 defines.

// File: rtl/sealed_call_check.sv
module sealed_call_check #(
  parameter int AW = 64,
  parameter int OTW = 24,
  parameter logic [OTW-1:0] MAX_SEALED_OT = 24'h03FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  input  logic          sel_i,
  input  logic          c_tag_i,
  input  logic          c_sealed_i,
  input  logic [OTW-1:0] c_otype_i,
  input  logic          c_px_i,
  input  logic          c_pcall_i,
  input  logic [AW-1:0] c_base_i,
  input  logic [AW:0]   c_top_i,
  input  logic [AW-1:0] c_off_i,
  input  logic          d_tag_i,
  input  logic          d_sealed_i,
  input  logic [OTW-1:0] d_otype_i,
  input  logic          d_px_i,
  input  logic          d_pcall_i,
  input  logic [AW-1:0] d_base_i,
  input  logic [AW:0]   d_top_i,
  input  logic [AW-1:0] d_off_i,
  output logic          rsp_valid_o,
  output logic          fault_o,
  output logic [2:0]    cause_o,
  output logic          fault_opnd_o,
  output logic [AW-1:0] target_o,
  output logic          ud_tag_o,
  output logic          ud_sealed_o,
  output logic [OTW-1:0] ud_otype_o,
  output logic          ud_px_o,
  output logic          ud_pcall_o,
  output logic [AW-1:0] ud_base_o,
  output logic [AW:0]   ud_top_o,
  output logic [AW-1:0] ud_off_o,
  output logic          uc_tag_o,
  output logic          uc_sealed_o,
  output logic [OTW-1:0] uc_otype_o,
  output logic          uc_px_o,
  output logic          uc_pcall_o,
  output logic [AW-1:0] uc_base_o,
  output logic [AW:0]   uc_top_o,
  output logic [AW-1:0] uc_off_o
);

  localparam logic [2:0] CS_NONE  = 3'd0;
  localparam logic [2:0] CS_TAG   = 3'd1;
  localparam logic [2:0] CS_SEAL  = 3'd2;
  localparam logic [2:0] CS_TYPE  = 3'd3;
  localparam logic [2:0] CS_EXEC  = 3'd4;
  localparam logic [2:0] CS_LEN   = 3'd5;
  localparam logic [2:0] CS_TRAP  = 3'd6;
  localparam logic [2:0] CS_CALLP = 3'd7;
  localparam logic [OTW-1:0] OT_UNSEALED = '1;

  logic [AW-1:0] c_cur;
  logic [AW:0]   c_end;
  logic          c_inb;
  logic [2:0]    cause_n;
  logic          opnd_n;
  logic          ok_n;

  assign c_cur = c_base_i + c_off_i;
  assign c_end = {1'b0, c_cur} + (AW+1)'(1);
  assign c_inb = (c_cur >= c_base_i) && !c_end[AW] && (c_end <= c_top_i);

  always_comb begin
    cause_n = CS_NONE;
    opnd_n  = 1'b0;
    if (!c_tag_i)                                          cause_n = CS_TAG;
    else if (!d_tag_i)                      begin cause_n = CS_TAG;  opnd_n = 1'b1; end
    else if (!c_sealed_i)                                  cause_n = CS_SEAL;
    else if (!d_sealed_i)                   begin cause_n = CS_SEAL; opnd_n = 1'b1; end
    else if (c_otype_i != d_otype_i || c_otype_i > MAX_SEALED_OT) cause_n = CS_TYPE;
    else if (!c_px_i)                                      cause_n = CS_EXEC;
    else if (d_px_i)                        begin cause_n = CS_EXEC; opnd_n = 1'b1; end
    else if (!c_inb)                                       cause_n = CS_LEN;
    else if (!sel_i)                                       cause_n = CS_TRAP;
    else if (!c_pcall_i)                                   cause_n = CS_CALLP;
    else if (!d_pcall_i)                    begin cause_n = CS_CALLP; opnd_n = 1'b1; end
  end

  assign ok_n = (cause_n == CS_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o  <= 1'b0;
      fault_o      <= 1'b0;
      cause_o      <= CS_NONE;
      fault_opnd_o <= 1'b0;
      target_o     <= '0;
      ud_tag_o <= 1'b0; ud_sealed_o <= 1'b0; ud_otype_o <= '0; ud_px_o <= 1'b0;
      ud_pcall_o <= 1'b0; ud_base_o <= '0; ud_top_o <= '0; ud_off_o <= '0;
      uc_tag_o <= 1'b0; uc_sealed_o <= 1'b0; uc_otype_o <= '0; uc_px_o <= 1'b0;
      uc_pcall_o <= 1'b0; uc_base_o <= '0; uc_top_o <= '0; uc_off_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        fault_o      <= !ok_n;
        cause_o      <= cause_n;
        fault_opnd_o <= opnd_n;
        target_o     <= ok_n ? c_cur : '0;
        ud_tag_o    <= ok_n;
        ud_sealed_o <= 1'b0;
        ud_otype_o  <= ok_n ? OT_UNSEALED : '0;
        ud_px_o     <= ok_n && d_px_i;
        ud_pcall_o  <= ok_n && d_pcall_i;
        ud_base_o   <= ok_n ? d_base_i : '0;
        ud_top_o    <= ok_n ? d_top_i  : '0;
        ud_off_o    <= ok_n ? d_off_i  : '0;
        uc_tag_o    <= ok_n;
        uc_sealed_o <= 1'b0;
        uc_otype_o  <= ok_n ? OT_UNSEALED : '0;
        uc_px_o     <= ok_n && c_px_i;
        uc_pcall_o  <= ok_n && c_pcall_i;
        uc_base_o   <= ok_n ? c_base_i : '0;
        uc_top_o    <= ok_n ? c_top_i  : '0;
        uc_off_o    <= ok_n ? c_off_i  : '0;
      end
    end
  end

endmodule

// File: rtl/sealed_call_check_sva.sv
module sealed_call_check_sva #(
  parameter int AW = 64,
  parameter int OTW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid_i,
  input logic          sel_i,
  input logic [AW-1:0] c_base_i,
  input logic [AW-1:0] c_off_i,
  input logic          rsp_valid_o,
  input logic          fault_o,
  input logic [2:0]    cause_o,
  input logic [AW-1:0] target_o,
  input logic          ud_tag_o,
  input logic          ud_sealed_o,
  input logic [OTW-1:0] ud_otype_o,
  input logic          uc_tag_o,
  input logic          uc_sealed_o,
  input logic [OTW-1:0] uc_otype_o
);

  a_r12_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> rsp_valid_o);

  a_r12_no_resp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !rsp_valid_o);

  a_r11_fault_clears_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && fault_o) |-> (target_o == '0 && !ud_tag_o && !uc_tag_o));

  a_r11_cause_matches_fault: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> (fault_o == (cause_o != 3'd0)));

  a_r7_trap_form_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && $past(req_valid_i && !sel_i)) |-> fault_o);

  a_r10_outputs_unsealed: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !fault_o) |-> (ud_otype_o == '1 && uc_otype_o == '1 &&
                                   !ud_sealed_o && !uc_sealed_o && ud_tag_o && uc_tag_o));

  a_r10_target_is_cursor: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !fault_o) |-> (target_o == $past(AW'(c_base_i + c_off_i))));

endmodule

bind sealed_call_check sealed_call_check_sva #(.AW(AW), .OTW(OTW)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .sel_i(sel_i),
  .c_base_i(c_base_i), .c_off_i(c_off_i), .rsp_valid_o(rsp_valid_o),
  .fault_o(fault_o), .cause_o(cause_o), .target_o(target_o),
  .ud_tag_o(ud_tag_o), .ud_sealed_o(ud_sealed_o), .ud_otype_o(ud_otype_o),
  .uc_tag_o(uc_tag_o), .uc_sealed_o(uc_sealed_o), .uc_otype_o(uc_otype_o)
);

// File: tb/sim_sealed_call_check.sv
module sim_sealed_call_check;
  localparam int AW = 64;
  localparam logic [23:0] MAXOT = 24'h03FFFF;

  typedef struct packed {
    logic        tag;
    logic        sealed;
    logic [23:0] otype;
    logic        px;
    logic        pcall;
    logic [AW-1:0] base;
    logic [AW:0]   top;
    logic [AW-1:0] off;
  } cap_t;

  typedef struct packed {
    logic        fault;
    logic [2:0]  cause;
    logic        opnd;
    logic [AW-1:0] target;
    cap_t        ud;
    cap_t        uc;
  } rsp_t;

  logic clk = 0, rst_n = 0, req_valid = 0, sel = 0;
  cap_t ci, di;

  logic rsp_valid, fault, opnd;
  logic [2:0] cause;
  logic [AW-1:0] target;
  cap_t ud, uc;

  int checks = 0, errors = 0;
  rsp_t exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  sealed_call_check u0 (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .sel_i(sel),
    .c_tag_i(ci.tag), .c_sealed_i(ci.sealed), .c_otype_i(ci.otype), .c_px_i(ci.px),
    .c_pcall_i(ci.pcall), .c_base_i(ci.base), .c_top_i(ci.top), .c_off_i(ci.off),
    .d_tag_i(di.tag), .d_sealed_i(di.sealed), .d_otype_i(di.otype), .d_px_i(di.px),
    .d_pcall_i(di.pcall), .d_base_i(di.base), .d_top_i(di.top), .d_off_i(di.off),
    .rsp_valid_o(rsp_valid), .fault_o(fault), .cause_o(cause), .fault_opnd_o(opnd),
    .target_o(target),
    .ud_tag_o(ud.tag), .ud_sealed_o(ud.sealed), .ud_otype_o(ud.otype), .ud_px_o(ud.px),
    .ud_pcall_o(ud.pcall), .ud_base_o(ud.base), .ud_top_o(ud.top), .ud_off_o(ud.off),
    .uc_tag_o(uc.tag), .uc_sealed_o(uc.sealed), .uc_otype_o(uc.otype), .uc_px_o(uc.px),
    .uc_pcall_o(uc.pcall), .uc_base_o(uc.base), .uc_top_o(uc.top), .uc_off_o(uc.off)
  );

  function automatic rsp_t model(input logic s, input cap_t c, input cap_t d);
    rsp_t r;
    logic [AW-1:0] cur;
    logic [AW:0] e;
    logic inb;
    r = '0;
    cur = c.base + c.off;
    e = {1'b0, cur} + 1;
    inb = (cur >= c.base) && (e[AW] == 1'b0) && (e <= c.top);
    if (!c.tag)                 r.cause = 3'd1;
    else if (!d.tag)      begin r.cause = 3'd1; r.opnd = 1; end
    else if (!c.sealed)         r.cause = 3'd2;
    else if (!d.sealed)   begin r.cause = 3'd2; r.opnd = 1; end
    else if (c.otype != d.otype || c.otype > MAXOT) r.cause = 3'd3;
    else if (!c.px)             r.cause = 3'd4;
    else if (d.px)        begin r.cause = 3'd4; r.opnd = 1; end
    else if (!inb)              r.cause = 3'd5;
    else if (!s)                r.cause = 3'd6;
    else if (!c.pcall)          r.cause = 3'd7;
    else if (!d.pcall)    begin r.cause = 3'd7; r.opnd = 1; end
    r.fault = (r.cause != 0);
    if (!r.fault) begin
      r.target = cur;
      r.ud = d; r.ud.sealed = 0; r.ud.otype = 24'hFFFFFF;
      r.uc = c; r.uc.sealed = 0; r.uc.otype = 24'hFFFFFF;
    end
    return r;
  endfunction

  task automatic send(input string rq, input logic s, input cap_t c, input cap_t d);
    @(negedge clk);
    sel = s; ci = c; di = d; req_valid = 1;
    exp_q.push_back(model(s, c, d));
    tag_q.push_back(rq);
    @(negedge clk);
    req_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      rsp_t got, ex;
      string rq;
      got = {fault, cause, opnd, target, ud, uc};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected response: actual valid=1 expected valid=0");
      end else begin
        ex = exp_q.pop_front();
        rq = tag_q.pop_front();
        if (got !== ex) begin
          errors++;
          $display("FAIL %s: actual fault=%0d cause=%0d opnd=%0d target=%h ud_ot=%h uc_ot=%h | expected fault=%0d cause=%0d opnd=%0d target=%h ud_ot=%h uc_ot=%h",
                   rq, got.fault, got.cause, got.opnd, got.target, got.ud.otype, got.uc.otype,
                   ex.fault, ex.cause, ex.opnd, ex.target, ex.ud.otype, ex.uc.otype);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cap_t gc, gd, c, d;
    gc = '{tag:1, sealed:1, otype:24'd5, px:1, pcall:1, base:64'h1000, top:65'h2000, off:64'h10};
    gd = '{tag:1, sealed:1, otype:24'd5, px:0, pcall:1, base:64'h8000, top:65'h9000, off:64'h40};
    ci = gc; di = gd;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || fault !== 0 || cause !== 0 || target !== 0 || ud.tag !== 0 || uc.tag !== 0) begin
      errors++;
      $display("FAIL R12 reset: actual valid=%0d fault=%0d cause=%0d target=%h expected all 0",
               rsp_valid, fault, cause, target);
    end
    rst_n = 1;
    repeat (2) @(negedge clk);
    checks++;
    if (rsp_valid !== 0) begin
      errors++;
      $display("FAIL R12 idle: actual valid=%0d expected 0", rsp_valid);
    end

    send("R10 success", 1, gc, gd);
    send("R7 trap selector", 0, gc, gd);
    c = gc; c.tag = 0;                 send("R1 code tag", 1, c, gd);
    d = gd; d.tag = 0;                 send("R1 data tag", 1, gc, d);
    send("R9 both tags clear", 1, c, d);
    c = gc; c.sealed = 0;              send("R2 code seal", 1, c, gd);
    d = gd; d.sealed = 0;              send("R2 data seal", 1, gc, d);
    d = gd; d.otype = 24'd6;           send("R3 type mismatch", 1, gc, d);
    c = gc; c.otype = MAXOT + 1; d = gd; d.otype = MAXOT + 1;
                                       send("R3 type above max", 1, c, d);
    c = gc; c.otype = MAXOT; d = gd; d.otype = MAXOT;
                                       send("R10 type at max", 1, c, d);
    c = gc; c.px = 0;                  send("R4 code exec", 1, c, gd);
    d = gd; d.px = 1;                  send("R5 data exec", 1, gc, d);
    c = gc; c.off = '1;                send("R6 cursor below base", 1, c, gd);
    c = gc; c.off = 64'h1000;          send("R6 cursor at top", 1, c, gd);
    c = gc; c.off = 64'hFFF;           send("R6 cursor last byte", 1, c, gd);
    c = gc; c.base = 64'hFFFF_FFFF_FFFF_FFF0; c.top = 65'h1_0000_0000_0000_0000; c.off = 64'hF;
                                       send("R6 cursor carry", 1, c, gd);
    c = gc; c.pcall = 0;               send("R8 code call perm", 1, c, gd);
    d = gd; d.pcall = 0;               send("R8 data call perm", 1, gc, d);
    send("R8 both call perm", 1, c, d);
    c = gc; c.px = 0; d = gd; d.sealed = 0;
                                       send("R9 seal before exec", 1, c, d);
    c = gc; c.off = 64'h1000;          send("R9 length before trap", 0, c, gd);
    c = gc; c.pcall = 0;               send("R11 trap form ignores call perm", 0, c, gd);
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R12 missing responses: actual %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule